// File: doc/BRIEF.md
# Sleep Mode Configuration Controller

This block holds the sleep-mode configuration of a mixed-signal device and a sticky, read-only shutdown flag. From them it derives the effective enables for three low-power resources: the 32 kHz oscillator, the 32 kHz clock output buffer and the PWM. A bus front end that is not part of this block decodes register accesses. It delivers them here as single-cycle strobes: a write to the configuration register with its data byte, a read of that register, a write to a dedicated sleep address, and a write to the normal-mode address. A day-alarm event and a wake-pin edge each arrive as a one-cycle pulse.

The device is asleep while the shutdown flag is set or while the external sleep input is high. While the device is asleep, each resource follows its sleep-mode enable from the configuration register, and the normal-mode enable supplied by the rest of the chip has no effect. While the device is awake, each resource follows its normal-mode enable. During sleep the PWM can only be clocked from the 32 kHz oscillator, so the PWM is held off whenever that oscillator is disabled for sleep.

Top module: `slp_ctrl`

## Requirements
- R1: After reset the shutdown flag is 0, the sleep oscillator enable (bit 7) and the sleep clock-output enable (bit 6) are 1, and the sleep PWM enable (bit 5) is 0. A read therefore returns 0xC0.
- R2: A configuration write with data bit 0 at 1 sets the shutdown flag, which is visible one cycle after the strobe.
- R3: A configuration write with data bit 0 at 0, and any configuration read, leave the shutdown flag unchanged. A configuration write loads bits 7, 6 and 5 of the data into the sleep oscillator, clock-output and PWM enables.
- R4: A write strobe to the sleep address sets the shutdown flag, which is visible one cycle after the strobe.
- R5: A normal-mode address write, a day-alarm pulse or a wake-pin edge pulse clears the shutdown flag, which is visible one cycle after the pulse.
- R6: When a set source and a clear source occur in the same cycle, the shutdown flag ends up 0.
- R7: `sleep_o` is high while the shutdown flag is set or `sleep_pin_i` is high. The shutdown flag keeps the device asleep after `sleep_pin_i` falls.
- R8: While asleep, `osc_en_o` equals the sleep oscillator enable and `ck_out_en_o` equals the sleep clock-output enable, whatever the normal-mode enables are.
- R9: While asleep, `pwm_en_o` is the sleep PWM enable ANDed with the sleep oscillator enable.
- R10: While awake, `osc_en_o`, `ck_out_en_o` and `pwm_en_o` equal `osc_en_norm_i`, `ck_out_en_norm_i` and `pwm_en_norm_i`.
- R11: A read strobe captures the register image into `rdata_o`, which is visible one cycle later. The image holds the three configuration bits in bits 7..5, the shutdown flag in bit 1, and 0 in bits 4, 3, 2 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Configuration register write strobe |
| cfg_rd_i | input | 1 | Configuration register read strobe |
| wdata_i | input | 8 | Write data for the configuration register |
| sleep_addr_wr_i | input | 1 | Write strobe to the sleep address |
| norm_addr_wr_i | input | 1 | Write strobe to the normal-mode address |
| day_alarm_i | input | 1 | Day-alarm wake pulse |
| wake_edge_i | input | 1 | Wake-pin edge pulse |
| sleep_pin_i | input | 1 | External sleep request level |
| osc_en_norm_i | input | 1 | Normal-mode oscillator enable |
| ck_out_en_norm_i | input | 1 | Normal-mode clock-output enable |
| pwm_en_norm_i | input | 1 | Normal-mode PWM enable |
| rdata_o | output | 8 | Captured register image |
| shdn_o | output | 1 | Shutdown flag |
| sleep_o | output | 1 | Effective sleep state |
| osc_en_o | output | 1 | Effective oscillator enable |
| ck_out_en_o | output | 1 | Effective clock-output buffer enable |
| pwm_en_o | output | 1 | Effective PWM enable |

## Verification
On every cycle the assertions check the set and clear timing of the shutdown flag: clear wins over set, and the flag holds when no source is active, which covers reads and writes with the command bit at 0. They also check that the flag forces sleep, that the PWM never runs in sleep without the oscillator, that the normal-mode enables pass through while awake, and where the flag sits in the read image. Only the bench scenarios show that the reset pattern is correct, that a write loads the right configuration bits, and that each sleep enable reaches its own output independently of the normal-mode enables.

// File: rtl/slp_ctrl_pkg.sv
package slp_ctrl_pkg;
  localparam int REG_W     = 8;
  localparam int NUM_RES   = 3;  // osc, clock out, pwm
  localparam int CMD_BIT   = 0;
  localparam int SHDN_BIT  = 1;
  localparam int SPWM_BIT  = 5;
  localparam int SCK_BIT   = 6;
  localparam int SOSC_BIT  = 7;
  localparam int RES_OSC   = 0;
  localparam int RES_CK    = 1;
  localparam int RES_PWM   = 2;

  typedef struct packed {
    logic sosc_en;
    logic sck_en;
    logic spwm_en;
  } slp_cfg_t;

  localparam slp_cfg_t CFG_RST = '{sosc_en: 1'b1, sck_en: 1'b1, spwm_en: 1'b0};
endpackage

// File: rtl/slp_cfg_reg.sv
module slp_cfg_reg
  import slp_ctrl_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  slp_cfg_t cfg_i,
  output slp_cfg_t cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_o <= CFG_RST;
    else if (wr_i) cfg_o <= cfg_i;
  end
endmodule

// File: rtl/slp_shdn_flag.sv
module slp_shdn_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (clr_i)  flag_o <= 1'b0;  // clear has priority
    else if (set_i)  flag_o <= 1'b1;
  end
endmodule

// File: rtl/slp_en_mux.sv
module slp_en_mux #(
  parameter int N = 3
) (
  input  logic         sleep_i,
  input  logic [N-1:0] slp_en_i,
  input  logic [N-1:0] norm_en_i,
  output logic [N-1:0] en_o
);
  for (genvar g = 0; g < N; g++) begin : g_res
    assign en_o[g] = sleep_i ? slp_en_i[g] : norm_en_i[g];
  end
endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
  import slp_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_wr_i,
  input  logic             cfg_rd_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             sleep_addr_wr_i,
  input  logic             norm_addr_wr_i,
  input  logic             day_alarm_i,
  input  logic             wake_edge_i,
  input  logic             sleep_pin_i,
  input  logic             osc_en_norm_i,
  input  logic             ck_out_en_norm_i,
  input  logic             pwm_en_norm_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             shdn_o,
  output logic             sleep_o,
  output logic             osc_en_o,
  output logic             ck_out_en_o,
  output logic             pwm_en_o
);
  slp_cfg_t           cfg_q, cfg_w;
  logic               shdn_q, set_req, clr_req;
  logic [NUM_RES-1:0] slp_vec, norm_vec, en_vec;
  logic [REG_W-1:0]   rimg, rdata_q;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i[SPWM_BIT-1:CMD_BIT+1];

  assign cfg_w.sosc_en = wdata_i[SOSC_BIT];
  assign cfg_w.sck_en  = wdata_i[SCK_BIT];
  assign cfg_w.spwm_en = wdata_i[SPWM_BIT];

  assign set_req = sleep_addr_wr_i | (cfg_wr_i & wdata_i[CMD_BIT]);
  assign clr_req = norm_addr_wr_i | day_alarm_i | wake_edge_i;

  slp_cfg_reg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (cfg_wr_i),
    .cfg_i  (cfg_w),
    .cfg_o  (cfg_q)
  );

  slp_shdn_flag u_shdn (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_req),
    .clr_i  (clr_req),
    .flag_o (shdn_q)
  );

  // pwm in sleep needs the 32 kHz source
  assign slp_vec[RES_OSC]  = cfg_q.sosc_en;
  assign slp_vec[RES_CK]   = cfg_q.sck_en;
  assign slp_vec[RES_PWM]  = cfg_q.spwm_en & cfg_q.sosc_en;
  assign norm_vec[RES_OSC] = osc_en_norm_i;
  assign norm_vec[RES_CK]  = ck_out_en_norm_i;
  assign norm_vec[RES_PWM] = pwm_en_norm_i;

  assign sleep_o = shdn_q | sleep_pin_i;

  slp_en_mux #(.N(NUM_RES)) u_mux (
    .sleep_i   (sleep_o),
    .slp_en_i  (slp_vec),
    .norm_en_i (norm_vec),
    .en_o      (en_vec)
  );

  always_comb begin
    rimg           = '0;
    rimg[SOSC_BIT] = cfg_q.sosc_en;
    rimg[SCK_BIT]  = cfg_q.sck_en;
    rimg[SPWM_BIT] = cfg_q.spwm_en;
    rimg[SHDN_BIT] = shdn_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (cfg_rd_i) rdata_q <= rimg;
  end

  assign rdata_o     = rdata_q;
  assign shdn_o      = shdn_q;
  assign osc_en_o    = en_vec[RES_OSC];
  assign ck_out_en_o = en_vec[RES_CK];
  assign pwm_en_o    = en_vec[RES_PWM];
endmodule

// File: rtl/slp_ctrl_chk.sv
module slp_ctrl_chk
  import slp_ctrl_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_wr_i,
  input logic             cfg_rd_i,
  input logic [REG_W-1:0] wdata_i,
  input logic             sleep_addr_wr_i,
  input logic             norm_addr_wr_i,
  input logic             day_alarm_i,
  input logic             wake_edge_i,
  input logic             sleep_pin_i,
  input logic             osc_en_norm_i,
  input logic             ck_out_en_norm_i,
  input logic             pwm_en_norm_i,
  input logic [REG_W-1:0] rdata_o,
  input logic             shdn_o,
  input logic             sleep_o,
  input logic             osc_en_o,
  input logic             ck_out_en_o,
  input logic             pwm_en_o
);
  logic any_clr;
  assign any_clr = norm_addr_wr_i | day_alarm_i | wake_edge_i;

  assert_cmd_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && wdata_i[CMD_BIT] && !any_clr) |=> shdn_o);

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_addr_wr_i && !(cfg_wr_i && wdata_i[CMD_BIT]) && !any_clr) |=> $stable(shdn_o));

  assert_addr_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_addr_wr_i && !any_clr) |=> shdn_o);

  // also covers R6: clear wins over any simultaneous set
  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_clr |=> !shdn_o);

  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shdn_o |-> sleep_o);

  assert_awake_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shdn_o && !sleep_pin_i) |-> !sleep_o);

  assert_pwm_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_o && pwm_en_o) |-> osc_en_o);

  assert_norm_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_o |-> (osc_en_o == osc_en_norm_i && ck_out_en_o == ck_out_en_norm_i
                  && pwm_en_o == pwm_en_norm_i));

  assert_rd_img_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rd_i |=> (rdata_o[SHDN_BIT] == $past(shdn_o) && rdata_o[CMD_BIT] == 1'b0
                  && rdata_o[SPWM_BIT-1:SHDN_BIT+1] == '0));
endmodule

bind slp_ctrl slp_ctrl_chk u_chk (.*);

// File: tb/tb_slp_ctrl.sv
module tb_slp_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 0, cfg_rd = 0, slp_wr = 0, nrm_wr = 0, alarm = 0, wake = 0, pin = 0;
  logic osc_n = 0, ck_n = 0, pwm_n = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic shdn, sleep, osc_en, ck_en, pwm_en;

  int total = 0, bad = 0;
  string cur_req = "R1";
  bit checking = 0;

  // reference model state
  int m_shdn, m_sosc, m_sck, m_spwm, m_rdata;

  always #4 clk = ~clk;

  slp_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_rd_i(cfg_rd), .wdata_i(wdata),
    .sleep_addr_wr_i(slp_wr), .norm_addr_wr_i(nrm_wr), .day_alarm_i(alarm),
    .wake_edge_i(wake), .sleep_pin_i(pin), .osc_en_norm_i(osc_n),
    .ck_out_en_norm_i(ck_n), .pwm_en_norm_i(pwm_n), .rdata_o(rdata), .shdn_o(shdn),
    .sleep_o(sleep), .osc_en_o(osc_en), .ck_out_en_o(ck_en), .pwm_en_o(pwm_en)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_shdn = 0; m_sosc = 1; m_sck = 1; m_spwm = 0; m_rdata = 0;
    end else begin
      int img;
      img = m_sosc * 128 + m_sck * 64 + m_spwm * 32 + m_shdn * 2;
      if (cfg_rd) m_rdata = img;
      if (nrm_wr || alarm || wake) m_shdn = 0;
      else if (slp_wr || (cfg_wr && wdata[0])) m_shdn = 1;
      if (cfg_wr) begin
        m_sosc = wdata[7]; m_sck = wdata[6]; m_spwm = wdata[5];
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking && rst_n) begin
      int ms, eo, ec, ep;
      ms = (m_shdn != 0 || pin) ? 1 : 0;
      eo = ms ? m_sosc : osc_n;
      ec = ms ? m_sck : ck_n;
      ep = ms ? (m_spwm & m_sosc) : pwm_n;
      chk("shdn", shdn, m_shdn);
      chk("sleep", sleep, ms);
      chk("osc_en", osc_en, eo);
      chk("ck_en", ck_en, ec);
      chk("pwm_en", pwm_en, ep);
      chk("rdata", rdata, m_rdata);
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
    cfg_wr = 0; cfg_rd = 0; slp_wr = 0; nrm_wr = 0; alarm = 0; wake = 0;
  endtask

  task automatic do_read();
    cfg_rd = 1; tick();
  endtask

  task automatic do_write(input logic [7:0] d);
    cfg_wr = 1; wdata = d; tick();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    checking = 1;
    // R1: reset pattern
    cur_req = "R1";
    chk("shdn at reset", shdn, 0);
    do_read(); tick();
    chk("reset image", rdata, 8'hC0);

    // R10: awake, normal enables pass through
    cur_req = "R10";
    for (int i = 0; i < 8; i++) begin
      osc_n = i[0]; ck_n = i[1]; pwm_n = i[2]; tick();
    end

    // R3: write with command bit clear, then reads
    cur_req = "R3";
    do_write(8'hA0); tick();
    chk("shdn after write bit0=0", shdn, 0);
    do_read(); do_read(); tick();
    chk("image after write", rdata, 8'hA0);

    // R2: command bit set -> sleep; R8 sleep enables win
    cur_req = "R2";
    osc_n = 0; ck_n = 0; pwm_n = 0;
    do_write(8'hE1);
    chk("shdn after cmd write", shdn, 1);
    cur_req = "R8";
    tick(2);
    chk("osc in sleep", osc_en, 1);
    chk("ck in sleep", ck_en, 1);
    osc_n = 1; ck_n = 1; pwm_n = 1;
    do_write(8'h00); tick();
    chk("osc off in sleep", osc_en, 0);
    chk("ck off in sleep", ck_en, 0);
    cur_req = "R3";
    chk("shdn held by write bit0=0", shdn, 1);
    do_read(); tick();
    chk("image with shdn", rdata, 8'h02);
    cur_req = "R8";
    do_write(8'h40); tick();
    chk("ck only", ck_en, 1);

    // R9: pwm gated by sleep oscillator enable
    cur_req = "R9";
    do_write(8'h20); tick();
    chk("pwm without osc", pwm_en, 0);
    do_write(8'hA0); tick();
    chk("pwm with osc", pwm_en, 1);

    // R5: each clear source
    cur_req = "R5";
    alarm = 1; tick();
    chk("day alarm clears", shdn, 0);
    cur_req = "R4";
    slp_wr = 1; tick();
    chk("sleep addr sets", shdn, 1);
    cur_req = "R5";
    wake = 1; tick();
    chk("wake edge clears", shdn, 0);
    cur_req = "R4";
    slp_wr = 1; tick();
    cur_req = "R5";
    nrm_wr = 1; tick();
    chk("normal write clears", shdn, 0);

    // R6: simultaneous set and clear
    cur_req = "R6";
    slp_wr = 1; alarm = 1; tick();
    chk("alarm beats sleep addr", shdn, 0);
    cfg_wr = 1; wdata = 8'hE1; nrm_wr = 1; tick();
    chk("normal beats cmd write", shdn, 0);
    slp_wr = 1; tick();
    slp_wr = 1; wake = 1; tick();
    chk("wake beats set while set", shdn, 0);

    // R7: sleep pin and sticky flag
    cur_req = "R7";
    pin = 1; osc_n = 0; tick();
    chk("pin forces sleep", sleep, 1);
    pin = 0; tick();
    chk("pin released", sleep, 0);
    slp_wr = 1; pin = 1; tick();
    pin = 0; tick(2);
    chk("flag keeps sleep", sleep, 1);
    cur_req = "R11";
    do_read(); tick();
    chk("final image", rdata, 8'hE2);
    wake = 1; tick(2);

    checking = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule